// File: doc/BRIEF.md
# Segmentation Offload TCP Flag Masker

This block sits beside a transmit segmentation offload engine and decides the TCP flag field of every segment that engine cuts from one large send. A send request carries the 12-bit flag field of the template header, the total payload length in bytes and the maximum segment size. The block walks through the send one segment at a time. For each segment it works out whether that segment is the first, a middle or the last one. It then emits the template flags ANDed with the mask chosen for that position.

Three 12-bit masks, one per position, are held in software-writable configuration registers. The masks let the same hardware produce either classical ECN behaviour (FIN and PSH only on the final segment, CWR only on the opening segment) or accurate ECN behaviour (CWR kept on all segments, the final segment unmasked). The masks are sampled when a send is accepted. Software can therefore reprogram them at any time without disturbing a send that is already being cut.

Top module: `tso_flag_masker`

## Requirements
- R1: After reset the masks read back as position 0 (first) = 0xFF6, position 1 (middle) = 0xF76, position 2 (last) = 0xF7F. The output is idle and the input is ready.
- R2: A cycle with cfg_we high writes cfg_wdata into the mask selected by cfg_addr (0 first, 1 middle, 2 last). cfg_rdata shows the selected mask combinationally. Reading with cfg_we low never changes any mask.
- R3: With the classical masks, a send with template flags 0xFFF gives 0xFF6 on segment 0, 0xF76 on each middle segment and 0xF7F on the last segment.
- R4: With the masks programmed to first=0xFF6, middle=0xFF6, last=0xFFF, segment flags follow those masks (accurate ECN setting).
- R5: A send that fits in one segment (length not above mss, including length 0) emits exactly one beat whose flags are the template ANDed with both the first and the last masks.
- R6: A send with mss not zero emits max(1, ceil(len/mss)) beats. out_idx counts 0, 1, 2, ... and out_last is high only on the final beat.
- R7: Mask writes made while a send is being emitted do not change that send's flags. The next accepted send uses the new values.
- R8: While out_valid is high and out_ready is low, out_valid, out_flags, out_idx and out_last hold steady.
- R9: A send accepted with mss = 0 emits no beat and raises err_pulse for exactly the one cycle after acceptance.
- R10: in_ready is low while a send is being emitted and returns high in the cycle after its last beat is taken.
- R11: A write to cfg_addr 3 changes no mask, and reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_addr | input | 2 | Mask select: 0 first, 1 middle, 2 last |
| cfg_wdata | input | 12 | Mask write value |
| cfg_rdata | output | 12 | Selected mask value |
| in_valid | input | 1 | Send request valid |
| in_ready | output | 1 | Block can accept a send |
| in_flags | input | 12 | Template header TCP flags |
| in_len | input | LEN_W | Total payload length in bytes |
| in_mss | input | LEN_W | Maximum segment size in bytes |
| out_valid | output | 1 | Segment beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_flags | output | 12 | Masked flags for this segment |
| out_idx | output | LEN_W | Segment index within the send |
| out_last | output | 1 | Beat is the final segment |
| err_pulse | output | 1 | One-cycle pulse for a rejected zero-mss send |

## Verification
On every cycle the assertions check the handshake rules. They check that output beats hold under backpressure, that the index starts at zero and steps by one, that input acceptance is locked out while a send is being emitted and freed after its last beat, and that a zero-mss send gives an error pulse and no beat. Only the bench scenarios can show that the flag values are right for each position, that single-segment sends combine the first and last masks, and that the beat count matches the length. They also show that mask writes made in the middle of a send are deferred and that reads and writes to the unused address have no effect. The bench does this by comparing the outputs with a reference model that keeps its own copy of the masks.

// File: rtl/tsofm_pkg.sv
package tsofm_pkg;
  localparam int FLAG_W = 12;
  localparam int NMASK  = 3;

  typedef enum logic [1:0] {
    MSEL_FIRST = 2'd0,
    MSEL_MID   = 2'd1,
    MSEL_LAST  = 2'd2,
    MSEL_SOLO  = 2'd3
  } msel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } st_e;

  typedef struct packed {
    logic [FLAG_W-1:0] last;
    logic [FLAG_W-1:0] mid;
    logic [FLAG_W-1:0] first;
  } maskset_t;
endpackage

// File: rtl/tsofm_mask_regs.sv
module tsofm_mask_regs
  import tsofm_pkg::*;
#(
  parameter logic [FLAG_W-1:0] RST_FIRST = 12'hFF6,
  parameter logic [FLAG_W-1:0] RST_MID   = 12'hF76,
  parameter logic [FLAG_W-1:0] RST_LAST  = 12'hF7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [FLAG_W-1:0] wdata,
  output logic [FLAG_W-1:0] rdata,
  output maskset_t          masks
);
  localparam logic [NMASK*FLAG_W-1:0] RST_ALL = {RST_LAST, RST_MID, RST_FIRST};

  logic [FLAG_W-1:0] reg_q [NMASK];
  logic [FLAG_W-1:0] reg_d [NMASK];
  logic [NMASK-1:0]  reg_en;

  for (genvar g = 0; g < NMASK; g++) begin : g_mask
    always_comb begin
      reg_en[g] = we && (addr == 2'(g));
      reg_d[g]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= RST_ALL[g*FLAG_W +: FLAG_W];
      end else if (reg_en[g]) begin
        reg_q[g] <= reg_d[g];
      end
    end
  end

  always_comb begin
    unique case (addr)
      2'd0:    rdata = reg_q[0];
      2'd1:    rdata = reg_q[1];
      2'd2:    rdata = reg_q[2];
      default: rdata = '0;
    endcase
    masks.first = reg_q[0];
    masks.mid   = reg_q[1];
    masks.last  = reg_q[2];
  end
endmodule

// File: rtl/tsofm_seg_sched.sv
module tsofm_seg_sched
  import tsofm_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [LEN_W-1:0]  in_mss,
  input  maskset_t          masks_live,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  seg_idx,
  output logic              seg_first,
  output logic              seg_last,
  output logic [FLAG_W-1:0] tmpl,
  output maskset_t          masks_held,
  output logic              err_pulse
);
  st_e               st_q, st_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  mss_q, mss_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [FLAG_W-1:0] tmpl_q, tmpl_d;
  maskset_t          msk_q, msk_d;
  logic              err_q, err_d;
  logic              accept, load_en, step_en, is_last;

  always_comb begin
    accept  = in_valid && (st_q == ST_IDLE);
    is_last = (rem_q <= mss_q);
    load_en = accept && (in_mss != '0);
    step_en = (st_q == ST_EMIT) && out_ready && !is_last;

    st_d   = st_q;
    rem_d  = rem_q;
    mss_d  = mss_q;
    idx_d  = idx_q;
    tmpl_d = tmpl_q;
    msk_d  = msk_q;
    err_d  = accept && (in_mss == '0);

    unique case (st_q)
      ST_IDLE: begin
        if (load_en) begin
          st_d   = ST_EMIT;
          rem_d  = in_len;
          mss_d  = in_mss;
          idx_d  = '0;
          tmpl_d = in_flags;
          msk_d  = masks_live;
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          if (is_last) begin
            st_d = ST_IDLE;
          end else begin
            rem_d = rem_q - mss_q;
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      mss_q  <= '0;
      tmpl_q <= '0;
      msk_q  <= '0;
    end else if (load_en) begin
      rem_q  <= rem_d;
      mss_q  <= mss_d;
      tmpl_q <= tmpl_d;
      msk_q  <= msk_d;
    end else if (step_en) begin
      rem_q  <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load_en || step_en) begin
      idx_q <= idx_d;
    end
  end

  always_comb begin
    in_ready   = (st_q == ST_IDLE);
    out_valid  = (st_q == ST_EMIT);
    seg_idx    = idx_q;
    seg_first  = (idx_q == '0);
    seg_last   = is_last;
    tmpl       = tmpl_q;
    masks_held = msk_q;
    err_pulse  = err_q;
  end
endmodule

// File: rtl/tsofm_flag_gen.sv
module tsofm_flag_gen
  import tsofm_pkg::*;
(
  input  logic              seg_first,
  input  logic              seg_last,
  input  logic [FLAG_W-1:0] tmpl,
  input  maskset_t          masks,
  output logic [FLAG_W-1:0] flags
);
  msel_e             sel;
  logic [FLAG_W-1:0] mask;

  always_comb begin
    unique case ({seg_first, seg_last})
      2'b11:   sel = MSEL_SOLO;
      2'b10:   sel = MSEL_FIRST;
      2'b01:   sel = MSEL_LAST;
      default: sel = MSEL_MID;
    endcase

    unique case (sel)
      MSEL_FIRST: mask = masks.first;
      MSEL_LAST:  mask = masks.last;
      MSEL_SOLO:  mask = masks.first & masks.last;
      default:    mask = masks.mid;
    endcase

    flags = tmpl & mask;
  end
endmodule

// File: rtl/tso_flag_masker.sv
module tso_flag_masker
  import tsofm_pkg::*;
#(
  parameter int                LEN_W     = 16,
  parameter logic [FLAG_W-1:0] RST_FIRST = 12'hFF6,
  parameter logic [FLAG_W-1:0] RST_MID   = 12'hF76,
  parameter logic [FLAG_W-1:0] RST_LAST  = 12'hF7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [FLAG_W-1:0] cfg_wdata,
  output logic [FLAG_W-1:0] cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [LEN_W-1:0]  in_mss,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLAG_W-1:0] out_flags,
  output logic [LEN_W-1:0]  out_idx,
  output logic              out_last,
  output logic              err_pulse
);
  maskset_t          masks_live;
  maskset_t          masks_held;
  logic [FLAG_W-1:0] tmpl;
  logic              seg_first;
  logic              seg_last;

  tsofm_mask_regs #(
    .RST_FIRST (RST_FIRST),
    .RST_MID   (RST_MID),
    .RST_LAST  (RST_LAST)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .masks (masks_live)
  );

  tsofm_seg_sched #(
    .LEN_W (LEN_W)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_flags   (in_flags),
    .in_len     (in_len),
    .in_mss     (in_mss),
    .masks_live (masks_live),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .seg_idx    (out_idx),
    .seg_first  (seg_first),
    .seg_last   (seg_last),
    .tmpl       (tmpl),
    .masks_held (masks_held),
    .err_pulse  (err_pulse)
  );

  tsofm_flag_gen u_gen (
    .seg_first (seg_first),
    .seg_last  (seg_last),
    .tmpl      (tmpl),
    .masks     (masks_held),
    .flags     (out_flags)
  );

  assign out_last = seg_last;
endmodule

// File: rtl/tsofm_checker.sv
module tsofm_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LEN_W-1:0] in_mss,
  input logic             out_valid,
  input logic             out_ready,
  input logic [11:0]      out_flags,
  input logic [LEN_W-1:0] out_idx,
  input logic             out_last,
  input logic             err_pulse
);
  assert_busy_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_end_frees_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_flags) && $stable(out_idx) && $stable(out_last)));

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_idx == $past(out_idx) + 1'b1));

  assert_start_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mss != '0) |=> (out_valid && out_idx == '0));

  assert_mss_zero_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mss == '0) |=> (err_pulse && !out_valid));

  assert_err_only_after_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready && in_mss == '0)) |=> !err_pulse);
endmodule

bind tso_flag_masker tsofm_checker #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mss    (in_mss),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flags (out_flags),
  .out_idx   (out_idx),
  .out_last  (out_last),
  .err_pulse (err_pulse)
);

// File: tb/tso_flag_masker_bench.sv
module tso_flag_masker_bench;
  localparam int LEN_W = 16;

  logic             clk;
  logic             rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_addr;
  logic [11:0]      cfg_wdata;
  logic [11:0]      cfg_rdata;
  logic             in_valid;
  logic             in_ready;
  logic [11:0]      in_flags;
  logic [LEN_W-1:0] in_len;
  logic [LEN_W-1:0] in_mss;
  logic             out_valid;
  logic             out_ready;
  logic [11:0]      out_flags;
  logic [LEN_W-1:0] out_idx;
  logic             out_last;
  logic             err_pulse;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [11:0] m_first, m_mid, m_last;

  tso_flag_masker #(.LEN_W(LEN_W)) u_tso_flag_masker (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int nseg_of(input int len, input int mss);
    if (len <= mss) return 1;
    return (len + mss - 1) / mss;
  endfunction

  function automatic logic [11:0] exp_flags(input logic [11:0] t, input int idx, input int n,
                                            input logic [11:0] f, input logic [11:0] m,
                                            input logic [11:0] l);
    logic [11:0] k;
    if (n == 1)              k = f & l;
    else if (idx == 0)       k = f;
    else if (idx == n - 1)   k = l;
    else                     k = m;
    return t & k;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == 2'd0) m_first = d;
    if (a == 2'd1) m_mid = d;
    if (a == 2'd2) m_last = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read_chk(input logic [1:0] a, input logic [11:0] e, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  task automatic run_send(input logic [11:0] t, input int len, input int mss,
                          input logic stall, input logic wr_mid, input string req);
    logic [11:0] sf, sm, sl;
    int n, k, guard;
    @(negedge clk);
    in_valid = 1'b1; in_flags = t; in_len = LEN_W'(len); in_mss = LEN_W'(mss);
    sf = m_first; sm = m_mid; sl = m_last;
    n = nseg_of(len, mss);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R10 busy", in_ready, 0);
    k = 0;
    guard = 0;
    while (k < n && guard < 4000) begin
      out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (wr_mid && $urandom_range(0, 3) == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 2'($urandom_range(0, 2));
        cfg_wdata = 12'($urandom);
        if (cfg_addr == 2'd0) m_first = cfg_wdata;
        if (cfg_addr == 2'd1) m_mid = cfg_wdata;
        if (cfg_addr == 2'd2) m_last = cfg_wdata;
      end else begin
        cfg_we = 1'b0;
      end
      #1;
      if (out_valid && out_ready) begin
        chk(out_flags == exp_flags(t, k, n, sf, sm, sl), req, out_flags,
            exp_flags(t, k, n, sf, sm, sl));
        chk(out_idx == LEN_W'(k), "R6 index", out_idx, k);
        chk(out_last == (k == n - 1), "R6 last marker", out_last, (k == n - 1));
        k++;
      end else if (!out_valid) begin
        chk(1'b0, "R6 beat missing", 0, 1);
        guard = 4000;
      end
      guard++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    cfg_we = 1'b0;
    #1;
    chk(in_ready && !out_valid, "R10 freed after last", {in_ready, out_valid}, 2);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_flags = '0; in_len = '0; in_mss = '0; out_ready = 1'b0;
    m_first = 12'hFF6; m_mid = 12'hF76; m_last = 12'hF7F;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1 && err_pulse == 1'b0, "R1 idle after reset",
        {out_valid, in_ready, err_pulse}, 3'b010);
    cfg_read_chk(2'd0, 12'hFF6, "R1 first reset");
    cfg_read_chk(2'd1, 12'hF76, "R1 middle reset");
    cfg_read_chk(2'd2, 12'hF7F, "R1 last reset");
    cfg_read_chk(2'd0, 12'hFF6, "R2 read leaves mask");

    // R3: classical masks, template all ones, four segments
    run_send(12'hFFF, 400, 100, 1'b0, 1'b0, "R3 classical flags");
    // R5: single segment, len below, equal and zero
    run_send(12'hFFF, 50, 100, 1'b0, 1'b0, "R5 single segment");
    run_send(12'hFFF, 100, 100, 1'b0, 1'b0, "R5 single segment exact");
    run_send(12'hFFF, 0, 100, 1'b0, 1'b0, "R5 zero length");
    // R6: off-by-one lengths
    run_send(12'h0A9, 101, 100, 1'b1, 1'b0, "R6 two segments");
    run_send(12'h3C5, 299, 100, 1'b1, 1'b0, "R6 ceil count");

    // R4: accurate ECN masks
    cfg_write(2'd1, 12'hFF6);
    cfg_write(2'd2, 12'hFFF);
    cfg_read_chk(2'd1, 12'hFF6, "R2 middle written");
    cfg_read_chk(2'd2, 12'hFFF, "R2 last written");
    run_send(12'hFFF, 500, 100, 1'b1, 1'b0, "R4 accurate flags");

    // R11: unused address
    cfg_write(2'd3, 12'h123);
    cfg_read_chk(2'd3, 12'h000, "R11 addr3 reads zero");
    cfg_read_chk(2'd0, 12'hFF6, "R11 first untouched");
    cfg_read_chk(2'd1, 12'hFF6, "R11 middle untouched");
    cfg_read_chk(2'd2, 12'hFFF, "R11 last untouched");

    // R9: zero mss
    @(negedge clk);
    in_valid = 1'b1; in_mss = '0; in_len = 16'd300; in_flags = 12'hFFF;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(err_pulse == 1'b1 && out_valid == 1'b0, "R9 error pulse", {err_pulse, out_valid}, 2);
    @(negedge clk);
    #1;
    chk(err_pulse == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1, "R9 pulse ends no beats",
        {err_pulse, out_valid, in_ready}, 1);

    // R7: mask writes during sends are deferred; R8 stalls
    for (int i = 0; i < 40; i++) begin
      run_send(12'($urandom), $urandom_range(0, 3000), $urandom_range(150, 1500),
               1'b1, 1'b1, "R7 latched masks");
    end
    // R3 again after restoring classical values
    cfg_write(2'd0, 12'hFF6);
    cfg_write(2'd1, 12'hF76);
    cfg_write(2'd2, 12'hF7F);
    run_send(12'hFFF, 1000, 333, 1'b1, 1'b0, "R3 classical restored");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule